// File: doc/BRIEF.md
# External Memory Access Sequencer

This block runs the bus cycles for one of three external memory areas. A core places a request (area, direction, address, data, byte selects) for one cycle; the sequencer drives the area's chip select, the address and data, the read strobe, and the write lines for the length of the access. It then returns a one-cycle acknowledge, with read data when the access is a read. Each area has its own configuration bits, supplied from outside by control registers. These bits select whether the four byte write lines act as individual write strobes or as byte enables beside a common write enable, and whether even parity is added per byte on writes and checked on reads.

The third area (index 2) can be stretched by an external wait pin. The pin is shared with an interrupt input, so it passes through a two-flop synchronizer. Its active level is programmable. During the first three cycles of an access it is not consulted. From the fourth cycle on, the access continues for as long as the synchronized wait stays active. A wait-capable area needs at least four cycles, so a shorter programmed length is flagged and raised to four.

Top module: `ext_mem_seq`

## Requirements
- R1: In idle, a `req_valid` pulse with `req_area` 0..2 starts an access whose length in cycles is `cfg_acc_len` (0 counts as 1). During the access, exactly the `mem_cs` bit of that area is high. `ack` is high for one cycle, the last cycle of the access. Requests with area 3, and requests made during an access, are ignored.
- R2: On a read, `mem_oe` is high from access cycle 2 through the last cycle. `rd_data` equals `mem_rdata` in the `ack` cycle and is zero in the `ack` cycle of a write.
- R3: With the area's `cfg_byte_mode` bit = 1 (strobe mode), a write drives `mem_bwe` = `req_be` from cycle 2 through the last cycle, with `mem_bwe` = 0 in cycle 1. `mem_we` stays low.
- R4: With the area's `cfg_byte_mode` bit = 0 (enable mode), a write drives `mem_bwe` = `req_be` from cycle 1, and `mem_we` is high from cycle 2 through the last cycle. Reads leave `mem_bwe` at 0 in both modes.
- R5: Wait stretching applies only to area 2, and only while `cfg_wait_dis` = 0. Otherwise an active wait pin does not change the access length.
- R6: `cfg_wait_pol` = 1 makes the wait pin active high. `cfg_wait_pol` = 0 makes it active low.
- R7: The wait pin is synchronized by two flops. It is ignored in access cycles 1 to 3. From cycle 4 on, the access is held while the synchronized wait is active. If the pin was active at the start and goes inactive before the clock edge that ends cycle r, the access lasts max(L, r+2) cycles, where L is the effective length.
- R8: `cfg_err` is high whenever `cfg_wait_dis` = 0 and `cfg_acc_len` < 4. In that case an area 2 access lasts 4 cycles, while areas 0 and 1 keep the programmed length.
- R9: `irq_out` is high when the synchronized wait pin is at its active level and `cfg_int_mask` = 0. With the mask set, it stays low.
- R10: When the area's `cfg_par_dis` bit is 0, `mem_wpar[i]` is the XOR of byte i (bits 8i+7..8i) of the write data, which gives even parity. With the bit at 1, `mem_wpar` is 0.
- R11: In the `ack` cycle of a read from a parity-enabled area, if any lane's `mem_rpar[i]` differs from the XOR of `mem_rdata` byte i, `par_err` is high for that cycle and `par_err_lane` gives the lowest such lane. Otherwise, and for parity-disabled areas, `par_err` = 0 and `par_err_lane` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request pulse from the core |
| req_write | input | 1 | 1 = write, 0 = read |
| req_area | input | 2 | Memory area index |
| req_addr | input | AW | Access address |
| req_wdata | input | 32 | Write data |
| req_be | input | 4 | Byte selects |
| ack | output | 1 | Last cycle of the access |
| rd_data | output | 32 | Read data, valid with ack |
| cfg_par_dis | input | 3 | Per-area parity disable |
| cfg_byte_mode | input | 3 | Per-area: 1 strobes, 0 byte enables |
| cfg_wait_dis | input | 1 | 1 disables wait on area 2 |
| cfg_wait_pol | input | 1 | 1 = wait active high |
| cfg_int_mask | input | 1 | Masks the interrupt from the shared pin |
| cfg_acc_len | input | 4 | Programmed access length in cycles |
| mem_cs | output | 3 | One-hot area select |
| mem_addr | output | AW | Address to memory |
| mem_oe | output | 1 | Read strobe |
| mem_we | output | 1 | Common write enable |
| mem_bwe | output | 4 | Byte write strobes or byte enables |
| mem_wdata | output | 32 | Write data to memory |
| mem_wpar | output | 4 | Write parity per byte |
| mem_rdata | input | 32 | Read data from memory |
| mem_rpar | input | 4 | Read parity per byte |
| wait_pin | input | 1 | Shared wait/interrupt pin |
| irq_out | output | 1 | Interrupt from the shared pin |
| cfg_err | output | 1 | Illegal wait/length combination |
| par_err | output | 1 | Read parity error pulse |
| par_err_lane | output | 2 | Lane of the parity error |

## Verification
The hardest case to reach from the ports is where the access ends after a wait stretch. The end point depends on when the pin is released, seen through two synchronizer flops, and on the rule that the first three cycles are ignored. To reach it, the stimulus sets the pin active several cycles before the request, so the synchronized level has settled. It then releases the pin at a counted falling edge inside the access, and compares the measured chip-select length with max(L, r+2). A short pulse that is released early in the access checks that the ignore window holds. The same release timing is repeated with the low-active level, and on areas and settings where wait has no effect.

// File: rtl/ems_pkg.sv
package ems_pkg;
  localparam int LANES    = 4;
  localparam int BYTE_W   = 8;
  localparam int DATA_W   = LANES * BYTE_W;
  localparam int LEN_W    = 4;
  localparam int WAIT_MIN = 4;
  localparam int LANE_W   = $clog2(LANES);

  typedef enum logic {ST_IDLE, ST_ACC} seq_st_t;

  function automatic logic even_par(input logic [BYTE_W-1:0] b);
    return ^b;
  endfunction

  // effective access length: zero counts as one, wait areas need WAIT_MIN
  function automatic logic [LEN_W-1:0] eff_len(input logic [LEN_W-1:0] len,
                                               input logic wait_on);
    logic [LEN_W-1:0] l;
    l = (len == '0) ? LEN_W'(1) : len;
    if (wait_on && (l < LEN_W'(WAIT_MIN))) l = LEN_W'(WAIT_MIN);
    return l;
  endfunction

  function automatic logic [LANE_W-1:0] first_lane(input logic [LANES-1:0] m);
    logic [LANE_W-1:0] r;
    r = '0;
    for (int i = LANES - 1; i >= 0; i--) if (m[i]) r = LANE_W'(i);
    return r;
  endfunction
endpackage

// File: rtl/ems_sync.sv
module ems_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic s1;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b0;
      q  <= 1'b0;
    end else begin
      s1 <= d;
      q  <= s1;
    end
  end
endmodule

// File: rtl/ems_parity.sv
module ems_parity
  import ems_pkg::*;
(
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] rdata,
  input  logic [LANES-1:0]  rpar,
  output logic [LANES-1:0]  wpar,
  output logic [LANES-1:0]  mism
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign wpar[g] = even_par(wdata[g*BYTE_W +: BYTE_W]);
    assign mism[g] = even_par(rdata[g*BYTE_W +: BYTE_W]) ^ rpar[g];
  end
endmodule

// File: rtl/ext_mem_seq.sv
module ext_mem_seq
  import ems_pkg::*;
#(
  parameter int AW        = 24,
  parameter int NUM_AREAS = 3,
  parameter int WAIT_AREA = 2,
  parameter int AREA_W    = $clog2(NUM_AREAS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic                 req_write,
  input  logic [AREA_W-1:0]    req_area,
  input  logic [AW-1:0]        req_addr,
  input  logic [DATA_W-1:0]    req_wdata,
  input  logic [LANES-1:0]     req_be,
  output logic                 ack,
  output logic [DATA_W-1:0]    rd_data,
  input  logic [NUM_AREAS-1:0] cfg_par_dis,
  input  logic [NUM_AREAS-1:0] cfg_byte_mode,
  input  logic                 cfg_wait_dis,
  input  logic                 cfg_wait_pol,
  input  logic                 cfg_int_mask,
  input  logic [LEN_W-1:0]     cfg_acc_len,
  output logic [NUM_AREAS-1:0] mem_cs,
  output logic [AW-1:0]        mem_addr,
  output logic                 mem_oe,
  output logic                 mem_we,
  output logic [LANES-1:0]     mem_bwe,
  output logic [DATA_W-1:0]    mem_wdata,
  output logic [LANES-1:0]     mem_wpar,
  input  logic [DATA_W-1:0]    mem_rdata,
  input  logic [LANES-1:0]     mem_rpar,
  input  logic                 wait_pin,
  output logic                 irq_out,
  output logic                 cfg_err,
  output logic                 par_err,
  output logic [LANE_W-1:0]    par_err_lane
);
  seq_st_t             st;
  logic [AREA_W-1:0]   area_q;
  logic                wr_q;
  logic [AW-1:0]       addr_q;
  logic [DATA_W-1:0]   wdata_q;
  logic [LANES-1:0]    be_q;
  logic [LEN_W-1:0]    cnt;

  // named internal events
  logic                busy, accept, wait_sync, wait_act, wait_area;
  logic                wait_window, wait_hold, last, phase2, bmode, par_on;
  logic [LEN_W-1:0]    len_eff;
  logic [LANES-1:0]    wpar_raw, mism;

  ems_sync u_sync (.clk(clk), .rst_n(rst_n), .d(wait_pin), .q(wait_sync));

  ems_parity u_par (
    .wdata(wdata_q), .rdata(mem_rdata), .rpar(mem_rpar),
    .wpar(wpar_raw), .mism(mism)
  );

  assign busy        = (st == ST_ACC);
  assign accept      = !busy && req_valid && (int'(req_area) < NUM_AREAS);
  assign wait_act    = cfg_wait_pol ? wait_sync : !wait_sync;
  assign wait_area   = busy && (area_q == AREA_W'(WAIT_AREA)) && !cfg_wait_dis;
  assign len_eff     = eff_len(cfg_acc_len, wait_area);
  assign wait_window = (cnt >= LEN_W'(WAIT_MIN));
  assign wait_hold   = wait_area && wait_window && wait_act;
  assign last        = busy && (cnt >= len_eff) && !wait_hold;
  assign phase2      = busy && (cnt >= LEN_W'(2));
  assign bmode       = cfg_byte_mode[area_q];
  assign par_on      = !cfg_par_dis[area_q];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      area_q  <= '0;
      wr_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      be_q    <= '0;
      cnt     <= '0;
    end else if (accept) begin
      st      <= ST_ACC;
      area_q  <= req_area;
      wr_q    <= req_write;
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
      be_q    <= req_be;
      cnt     <= LEN_W'(1);
    end else if (busy) begin
      if (last) st <= ST_IDLE;
      else if (cnt != '1) cnt <= cnt + LEN_W'(1);
    end
  end

  for (genvar g = 0; g < NUM_AREAS; g++) begin : g_cs
    assign mem_cs[g] = busy && (area_q == AREA_W'(g));
  end

  always_comb begin
    mem_bwe = '0;
    if (busy && wr_q) begin
      if (!bmode)      mem_bwe = be_q;
      else if (phase2) mem_bwe = be_q;
    end
  end

  assign mem_addr     = addr_q;
  assign mem_wdata    = wdata_q;
  assign mem_oe       = phase2 && !wr_q;
  assign mem_we       = phase2 && wr_q && !bmode;
  assign mem_wpar     = (busy && par_on) ? wpar_raw : '0;
  assign ack          = last;
  assign rd_data      = (last && !wr_q) ? mem_rdata : '0;
  assign par_err      = last && !wr_q && par_on && (|mism);
  assign par_err_lane = par_err ? first_lane(mism) : '0;
  assign irq_out      = wait_act && !cfg_int_mask;
  assign cfg_err      = !cfg_wait_dis && (cfg_acc_len < LEN_W'(WAIT_MIN));

  // assertions
  assert_ack_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);
  assert_cs_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(mem_cs));
  assert_setup_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (!mem_we && !mem_oe));
  assert_bwe_in_access_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (|mem_bwe) |-> (|mem_cs));
  assert_wait_stretch_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wait_hold |=> (|mem_cs));
  assert_min_len_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && wait_area) |-> (cnt >= LEN_W'(WAIT_MIN)));
  assert_perr_on_read_R11: assert property (@(posedge clk) disable iff (!rst_n)
    par_err |-> (ack && !wr_q));
endmodule

// File: tb/ext_mem_seq_tb.sv
`timescale 1ns/1ps
module ext_mem_seq_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        req_valid = 0, req_write = 0;
  logic [1:0]  req_area = 0;
  logic [23:0] req_addr = 0;
  logic [31:0] req_wdata = 0;
  logic [3:0]  req_be = 0;
  logic        ack;
  logic [31:0] rd_data;
  logic [2:0]  cfg_par_dis = 3'b111, cfg_byte_mode = 3'b111;
  logic        cfg_wait_dis = 1, cfg_wait_pol = 1, cfg_int_mask = 1;
  logic [3:0]  cfg_acc_len = 4'd3;
  logic [2:0]  mem_cs;
  logic [23:0] mem_addr;
  logic        mem_oe, mem_we;
  logic [3:0]  mem_bwe, mem_wpar;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata = 0;
  logic [3:0]  mem_rpar = 0;
  logic        wait_pin = 0;
  logic        irq_out, cfg_err, par_err;
  logic [1:0]  par_err_lane;

  ext_mem_seq u_dut (.*);

  int checks = 0, failures = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  typedef struct {
    string tag; int len; logic [31:0] rdata; logic perr; logic [1:0] lane;
    logic [3:0] bwe1, bwe2, wpar; logic we2, oe2;
  } exp_t;
  exp_t sbq[$];

  // monitor
  int cyc = 0;
  logic [3:0] c_bwe1 = 0, c_bwe2 = 0, c_wpar = 0;
  logic c_we2 = 0, c_oe2 = 0;
  always @(negedge clk) begin
    if (rst_n && (|mem_cs)) begin
      cyc = cyc + 1;
      if (cyc == 1) c_bwe1 = mem_bwe;
      if (cyc == 2) begin
        c_bwe2 = mem_bwe; c_we2 = mem_we; c_oe2 = mem_oe; c_wpar = mem_wpar;
      end
      if (ack) begin
        if (sbq.size() == 0) chk(0, "R1", "unexpected ack", 1, 0);
        else begin
          exp_t e;
          e = sbq.pop_front();
          chk(cyc == e.len, e.tag, "length", cyc, e.len);
          chk(rd_data == e.rdata, "R2", "rd_data", rd_data, e.rdata);
          chk(par_err == e.perr, "R11", "par_err", par_err, e.perr);
          chk(par_err_lane == e.lane, "R11", "lane", par_err_lane, e.lane);
          chk(c_bwe1 == e.bwe1, e.tag, "bwe cycle1", c_bwe1, e.bwe1);
          chk(c_bwe2 == e.bwe2, e.tag, "bwe cycle2", c_bwe2, e.bwe2);
          chk(c_we2 == e.we2, e.tag, "we cycle2", c_we2, e.we2);
          chk(c_oe2 == e.oe2, "R2", "oe cycle2", c_oe2, e.oe2);
          chk(c_wpar == e.wpar, "R10", "wpar", c_wpar, e.wpar);
        end
        cyc = 0; c_bwe1 = 0; c_bwe2 = 0; c_wpar = 0; c_we2 = 0; c_oe2 = 0;
      end
    end
  end

  function automatic logic [3:0] bpar(input logic [31:0] d);
    return {^d[31:24], ^d[23:16], ^d[15:8], ^d[7:0]};
  endfunction

  // driver: wait_rel < 0 leaves the pin alone, else the pin is held active
  // from before the request and released at the falling edge of cycle wait_rel
  task automatic access(input string tag, input logic [1:0] area, input bit wr,
                        input logic [31:0] wd, input logic [3:0] be,
                        input logic [31:0] rd, input logic [3:0] rp,
                        input int wait_rel);
    exp_t e;
    int l;
    bit wa, pe, bm;
    logic [3:0] mm;
    l  = (cfg_acc_len == 0) ? 1 : int'(cfg_acc_len);
    wa = (area == 2) && !cfg_wait_dis;
    if (wa && l < 4) l = 4;
    if (wa && wait_rel >= 0 && wait_rel + 2 > l) l = wait_rel + 2;
    pe = !cfg_par_dis[area];
    bm = cfg_byte_mode[area];
    mm = rp ^ bpar(rd);
    e.tag  = tag;
    e.len  = l;
    e.rdata = wr ? 32'h0 : rd;
    e.perr = !wr && pe && (|mm);
    e.lane = 2'd0;
    if (e.perr) begin
      for (int i = 3; i >= 0; i--) if (mm[i]) e.lane = 2'(i);
    end
    e.bwe1 = (wr && !bm) ? be : 4'h0;
    e.bwe2 = (l >= 2 && wr) ? be : 4'h0;
    e.we2  = (l >= 2) && wr && !bm;
    e.oe2  = (l >= 2) && !wr;
    e.wpar = (l >= 2 && pe) ? bpar(wd) : 4'h0;
    if (wait_rel >= 0) begin
      wait_pin = cfg_wait_pol;
      repeat (3) @(negedge clk);
    end
    sbq.push_back(e);
    mem_rdata = rd; mem_rpar = rp;
    req_area = area; req_write = wr; req_wdata = wd; req_be = be;
    req_addr = req_addr + 24'h40;
    req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    if (wait_rel >= 0) begin
      repeat (wait_rel - 1) @(negedge clk);
      wait_pin = !cfg_wait_pol;
    end
    for (int t = 0; t < 200 && sbq.size() != 0; t++) @(negedge clk);
    if (sbq.size() != 0) begin
      chk(0, tag, "no ack", 0, 1);
      sbq.delete();
    end
    repeat (3) @(negedge clk);
  endtask

  initial begin : watchdog
    for (int i = 0; i < 100000 && !done; i++) @(posedge clk);
    if (!done) begin
      chk(0, "R1", "watchdog expired", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // reset state
    chk(mem_cs == 0, "R1", "cs in reset", 32'(mem_cs), 0);
    chk(ack == 0 && par_err == 0, "R1", "ack/perr in reset", {ack, par_err}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk(mem_bwe == 0 && !mem_we && !mem_oe, "R1", "idle strobes",
        {mem_bwe, mem_we, mem_oe}, 0);

    // R1/R2 reads, lengths 3 and 0 (counts as 1)
    access("R1", 2'd0, 0, 0, 4'hF, 32'hA5A5_1234, 4'h0, -1);
    cfg_acc_len = 0;
    access("R1", 2'd1, 0, 0, 4'hF, 32'h0000_00FF, 4'h0, -1);
    cfg_acc_len = 6;
    access("R2", 2'd2, 0, 0, 4'hF, 32'hDEAD_BEEF, 4'h0, -1);

    // R3 strobe mode write, R4 enable mode write and read
    cfg_acc_len = 3;
    access("R3", 2'd1, 1, 32'h1122_3344, 4'b0101, 0, 0, -1);
    cfg_byte_mode = 3'b101;
    access("R4", 2'd1, 1, 32'h5566_7788, 4'b1010, 0, 0, -1);
    access("R4", 2'd1, 0, 0, 4'b1010, 32'h0F0F_0F0F, 4'h0, -1);
    cfg_byte_mode = 3'b111;

    // R10/R11 parity
    cfg_par_dis = 3'b110;
    access("R10", 2'd0, 1, 32'h0103_0700, 4'hF, 0, 0, -1);
    access("R11", 2'd0, 0, 0, 4'hF, 32'h0103_0700, 4'b1100, -1);
    access("R11", 2'd0, 0, 0, 4'hF, 32'h0103_0701, bpar(32'h0103_0701) ^ 4'b0010, -1);
    access("R11", 2'd0, 0, 0, 4'hF, 32'h8001_0203, bpar(32'h8001_0203), -1);
    access("R11", 2'd1, 0, 0, 4'hF, 32'h0000_0001, 4'h0, -1);
    cfg_par_dis = 3'b111;

    // R5/R7 wait stretching
    cfg_acc_len = 5; cfg_wait_dis = 0;
    access("R7", 2'd2, 0, 0, 4'hF, 32'h7, 4'h1, 7);
    access("R7", 2'd2, 0, 0, 4'hF, 32'h8, 4'h1, 1);
    access("R5", 2'd0, 0, 0, 4'hF, 32'h9, 4'h0, 7);
    cfg_wait_dis = 1;
    access("R5", 2'd2, 0, 0, 4'hF, 32'hA, 4'h0, 7);

    // R8 illegal length
    cfg_acc_len = 2; cfg_wait_dis = 0;
    @(negedge clk);
    chk(cfg_err == 1, "R8", "cfg_err set", cfg_err, 1);
    access("R8", 2'd2, 1, 32'h1, 4'h1, 0, 0, -1);
    access("R8", 2'd0, 1, 32'h2, 4'h2, 0, 0, -1);
    cfg_acc_len = 4;
    @(negedge clk);
    chk(cfg_err == 0, "R8", "cfg_err clear at 4", cfg_err, 0);

    // R6 low-active wait
    cfg_wait_pol = 0; wait_pin = 1;
    repeat (3) @(negedge clk);
    access("R6", 2'd2, 0, 0, 4'hF, 32'h6, 4'h0, 6);

    // R9 interrupt masking (pin still low-active)
    cfg_int_mask = 1; wait_pin = 0;
    repeat (3) @(negedge clk);
    chk(irq_out == 0, "R9", "irq masked", irq_out, 0);
    cfg_int_mask = 0;
    #1 chk(irq_out == 1, "R9", "irq unmasked", irq_out, 1);
    wait_pin = 1;
    repeat (3) @(negedge clk);
    chk(irq_out == 0, "R9", "irq idle level", irq_out, 0);
    cfg_int_mask = 1; cfg_wait_pol = 1; wait_pin = 0; cfg_wait_dis = 1;
    repeat (3) @(negedge clk);

    // R1 area 3 ignored
    req_area = 2'd3; req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    repeat (6) @(negedge clk);
    chk(cyc == 0 && mem_cs == 0, "R1", "area 3 ignored", 32'(cyc), 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule